// File: doc/BRIEF.md
# Half-Rate Two-Mode Duobinary Serializer

This block is the last 2:1 merge of a serial transmitter. It takes two NRZ bit lanes on every clock cycle and emits two line symbols per cycle, one for each half of a 50% duty-cycle clock. The block therefore runs at half the line symbol rate. The duobinary precoder sits inside this merge. Its recursion runs from lane A to lane B within one cycle, and from lane B to the next cycle's lane A through a single history bit.

A mode input picks the output form. With the mode low, the block sends the precoded binary stream and leaves the spectral shaping to a lossy channel. With the mode high, the block also applies the 1+D sum and sends a three-level symbol. This digital model covers only the merge and coding logic. It does not model clock generation, analog drivers or earlier serializer stages.

Top module: `duob_merge2`

## Requirements
- R1: Lane A is the earlier bit in time. `sym_a` and `sym_b` are registered and show the result for the lane bits sampled at the previous rising edge.
- R2: The precoded bit is p[n] = d[n] XOR p[n-1]. Lane B uses the lane-A precoded bit from the same cycle. Lane A uses the lane-B precoded bit from the previous cycle.
- R3: When `mode_sel` = 0 was sampled, each symbol equals p[n], encoded as 2'd0 or 2'd1. Bit 1 of the symbol is 0.
- R4: When `mode_sel` = 1 was sampled, each symbol equals p[n] + p[n-1], encoded as 2'd0, 2'd1 or 2'd2.
- R5: When `mode_sel` = 1 was sampled, bit 0 of each symbol equals the lane bit it came from.
- R6: When `mode_sel` = 1 was sampled, `sym_a` and `sym_b` from the same cycle are never 0 and 2 in either order.
- R7: A synchronous reset clears the history bit to 0 and drives both symbols to 0 at the next edge.
- R8: A change of `mode_sel` takes effect at the next edge and leaves the history bit as it is.
- R9: The first lane-A symbol after reset is computed with a history of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock, 50% duty cycle |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0: precoded binary, 1: precoded plus 1+D |
| lane_a | input | 1 | Earlier data bit of the pair |
| lane_b | input | 1 | Later data bit of the pair |
| sym_a | output | 2 | Symbol for the first half-cycle slot |
| sym_b | output | 2 | Symbol for the second half-cycle slot |

## Verification
The assertions assume that the lane bits and `mode_sel` are known and steady at each rising edge. They also assume that reset is held for the first edge, so that every `$past` reference starts from a cleared state. The bench drives all inputs at the falling edge. It asserts reset from time zero, and it switches the mode only between full cycles, so every assumption holds. Random lane pairs, solid runs and alternating patterns are applied in both modes, together with mode toggles and mid-stream resets.

// File: rtl/duob_merge2.sv
module duob_merge2 (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_sel,
  input  logic       lane_a,
  input  logic       lane_b,
  output logic [1:0] sym_a,
  output logic [1:0] sym_b
);

  logic hist_q;
  logic pre_a, pre_b;
  logic [1:0] nxt_a, nxt_b;

  assign pre_a = lane_a ^ hist_q;
  assign pre_b = lane_b ^ pre_a;

  always_comb begin
    if (mode_sel) begin
      nxt_a = {1'b0, pre_a} + {1'b0, hist_q};
      nxt_b = {1'b0, pre_b} + {1'b0, pre_a};
    end else begin
      nxt_a = {1'b0, pre_a};
      nxt_b = {1'b0, pre_b};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      sym_a  <= 2'd0;
      sym_b  <= 2'd0;
    end else begin
      hist_q <= pre_b;
      sym_a  <= nxt_a;
      sym_b  <= nxt_b;
    end
  end

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sym_a == 2'd0 && sym_b == 2'd0));

  assert_binary_msb_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_sel)) |-> (sym_a[1] == 1'b0 && sym_b[1] == 1'b0));

  assert_decode_lsb_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel)) |-> (sym_a[0] == $past(lane_a) && sym_b[0] == $past(lane_b)));

  assert_no_extreme_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel)) |->
      !((sym_a == 2'd0 && sym_b == 2'd2) || (sym_a == 2'd2 && sym_b == 2'd0)));

endmodule

// File: tb/sim_duob_merge2.sv
`timescale 1ns/1ps
module sim_duob_merge2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic lane_a = 1'b0;
  logic lane_b = 1'b0;
  logic [1:0] sym_a, sym_b;

  int checks = 0;
  int failures = 0;
  int hist = 0;
  int exp_a = 0, exp_b = 0;
  bit have_exp = 0, exp_m1 = 0, exp_rst = 0;
  bit exp_da = 0, exp_db = 0;
  string exp_tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  duob_merge2 u0 (.clk(clk), .rst(rst), .mode_sel(mode_sel), .lane_a(lane_a),
                  .lane_b(lane_b), .sym_a(sym_a), .sym_b(sym_b));

  task automatic chk(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit r, input bit m, input bit a, input bit b, input string tag);
    int pa, pb;
    @(negedge clk);
    if (have_exp) begin
      chk(sym_a, exp_a, exp_rst ? "R7 sym_a" : {exp_tag, " sym_a"});
      chk(sym_b, exp_b, exp_rst ? "R7 sym_b" : {exp_tag, " sym_b"});
      if (!exp_rst && exp_m1) begin
        chk(sym_a % 2, exp_da, "R5 decode a");
        chk(sym_b % 2, exp_db, "R5 decode b");
        chk(((sym_a == 0 && sym_b == 2) || (sym_a == 2 && sym_b == 0)) ? 1 : 0, 0, "R6 adjacency");
      end
    end
    rst = r; mode_sel = m; lane_a = a; lane_b = b;
    if (r) begin
      hist = 0; exp_a = 0; exp_b = 0;
    end else begin
      pa = a ^ hist;
      pb = b ^ pa;
      if (m) begin exp_a = pa + hist; exp_b = pb + pa; end
      else   begin exp_a = pa;        exp_b = pb;      end
      hist = pb;
    end
    have_exp = 1; exp_rst = r; exp_m1 = m; exp_da = a; exp_db = b;
    exp_tag = tag;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, "R7");
    step(1, 1, 1, 1, "R7");
    step(0, 1, 1, 0, "R9 first after reset");
    step(0, 1, 0, 1, "R4");
    step(0, 1, 1, 1, "R2");
    step(0, 0, 1, 1, "R8 to mode0");
    step(0, 0, 0, 0, "R3");
    step(0, 1, 0, 1, "R8 to mode1");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, "R3 ones");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, "R4 ones");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0, "R4 alternating");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R2 alternating");
    step(0, 1, 1, 0, "R1");
    step(1, 1, 1, 1, "R7 midstream");
    step(0, 0, 1, 0, "R9 mode0");
    for (int i = 0; i < 400; i++) begin
      bit m = $urandom_range(0, 1);
      step((i % 97) == 50, m, $urandom_range(0, 1), $urandom_range(0, 1),
           m ? "R4 random" : "R3 random");
    end
    for (int i = 0; i < 200; i++)
      step(0, i[4], $urandom_range(0, 1), $urandom_range(0, 1), "R8 random toggles");
    step(0, 0, 0, 0, "R1 final");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule